// File: doc/BRIEF.md
# Dual Timer Output Waveform Controller

This block produces the output waveforms of a pair of timer channels, one narrow and one wide, while they transmit. Each channel output is a register. It goes to a programmed start level when the channel begins counting and flips on every terminal-count pulse from its counter. While the channel is stopped, the output sits at the opposite of the start level, so starting the channel always produces a visible edge. The counters are outside this block; only their terminal-count pulses come in.

A two-bit submode picks the relationship between the channels. In independent operation, each channel runs on its own enable. In alternating operation, the narrow channel runs first, and a terminal count on the running channel hands control to the other one. Two further codes pin the wide output to a constant level at once. A second two-bit field merges the two outputs onto a single pin through one of four gate functions.

Top module: `tmr_wave_ctrl`

## Requirements
- R1: The merged output `mix_o` follows the channel outputs without a clock, using `merge_i` as follows: 00 AND, 01 OR, 10 NOR, 11 NAND.
- R2: With `submode_i` = 00 (independent), each channel runs exactly while its own enable is high.
- R3: With `submode_i` = 10 the wide output `wide_o` is 0, and with 11 it is 1. Each takes effect in the same cycle, with no clock edge needed.
- R4: At the first clock edge where a channel's run condition is true, its output becomes that channel's start-level bit.
- R5: At every clock edge where a channel's run condition is false, its output becomes the inverse of its start-level bit.
- R6: At a clock edge where a channel was already running and still runs, the output inverts if that channel's terminal-count pulse is high, and otherwise holds.
- R7: With `submode_i` = 01 (alternating), the narrow channel runs first. A terminal count on the running channel stops that channel and starts the other one from the next edge.
- R8: Changing `submode_i` to 00 ends alternation. A terminal count arriving in the same cycle as the change causes no handover, and both channels then run on their enables.
- R9: In the two forcing codes the wide start-level bit has no effect on `wide_o`.
- R10: While `rst_ni` is low, both channel outputs are 0 and alternation points at the narrow channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_nar_i | input | 1 | Narrow channel enable |
| run_wid_i | input | 1 | Wide channel enable |
| tc_nar_i | input | 1 | Narrow counter terminal-count pulse |
| tc_wid_i | input | 1 | Wide counter terminal-count pulse |
| lvl_nar_i | input | 1 | Narrow channel start level |
| lvl_wid_i | input | 1 | Wide channel start level |
| submode_i | input | 2 | 00 independent, 01 alternating, 10 wide forced low, 11 wide forced high |
| merge_i | input | 2 | Merge function select |
| narrow_o | output | 1 | Narrow channel output |
| wide_o | output | 1 | Wide channel output |
| mix_o | output | 1 | Merged output |

## Verification
Two functions can meet in the same cycle. One is the alternating handover triggered by a terminal count. The other is leaving alternation by switching the submode to independent. The bench puts the narrow channel into its running phase of alternation, then raises its terminal-count pulse in the same cycle that the submode returns to 00. It judges the result at the wide output right after that edge: the wide output must already hold its start level, as a channel started by its own enable. The handover path would instead hold the wide output at the inverse level for one more cycle. A later terminal count then shows that the narrow channel is still running.

// File: rtl/tmr_wave_pkg.sv
package tmr_wave_pkg;
   typedef enum logic [1:0] {
      MRG_AND  = 2'b00,
      MRG_OR   = 2'b01,
      MRG_NOR  = 2'b10,
      MRG_NAND = 2'b11
   } merge_e;

   typedef enum logic [1:0] {
      SUB_INDEP = 2'b00,
      SUB_ALT   = 2'b01,
      SUB_LOW   = 2'b10,
      SUB_HIGH  = 2'b11
   } submode_e;

   function automatic logic merge_fn(input merge_e sel, input logic a, input logic b);
      logic r;
      unique case (sel)
         MRG_AND:  r = a & b;
         MRG_OR:   r = a | b;
         MRG_NOR:  r = ~(a | b);
         default:  r = ~(a & b);
      endcase
      return r;
   endfunction
endpackage

// File: rtl/tmr_wave_chan.sv
module tmr_wave_chan (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic tc_i,
   input  logic lvl_i,
   output logic out_o
);
   logic ran_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ran_q <= 1'b0;
         out_o <= 1'b0;
      end else begin
         ran_q <= run_i;
         if (!run_i)
            out_o <= ~lvl_i;
         else if (!ran_q)
            out_o <= lvl_i;
         else if (tc_i)
            out_o <= ~out_o;
      end
   end

   assert_idle_level_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> out_o == ~$past(lvl_i));
   assert_start_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && !ran_q) |=> out_o == $past(lvl_i));
   assert_tc_toggle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && ran_q && tc_i) |=> out_o != $past(out_o));
endmodule

// File: rtl/tmr_wave_seq.sv
module tmr_wave_seq
   import tmr_wave_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_ni,
   input  submode_e mode_i,
   input  logic     en_nar_i,
   input  logic     en_wid_i,
   input  logic     tc_nar_i,
   input  logic     tc_wid_i,
   output logic     run_nar_o,
   output logic     run_wid_o
);
   logic turn_wid_q;
   logic alt;

   assign alt       = (mode_i == SUB_ALT);
   assign run_nar_o = en_nar_i & (~alt | ~turn_wid_q);
   assign run_wid_o = en_wid_i & ((mode_i == SUB_INDEP) | (alt & turn_wid_q));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         turn_wid_q <= 1'b0;
      else if (!alt)
         turn_wid_q <= 1'b0;
      else if (!turn_wid_q && run_nar_o && tc_nar_i)
         turn_wid_q <= 1'b1;
      else if (turn_wid_q && run_wid_o && tc_wid_i)
         turn_wid_q <= 1'b0;
   end

   assert_alt_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i != SUB_ALT) |=> !turn_wid_q);
   assert_alt_handover_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (alt && !turn_wid_q && en_nar_i && tc_nar_i) |=> turn_wid_q);
endmodule

// File: rtl/tmr_wave_mix.sv
module tmr_wave_mix
   import tmr_wave_pkg::*;
#(
   parameter int unsigned MIX_REG = 0
) (
   input  logic   clk_i,
   input  logic   rst_ni,
   input  merge_e sel_i,
   input  logic   a_i,
   input  logic   b_i,
   output logic   mix_o
);
   logic raw;
   assign raw = merge_fn(sel_i, a_i, b_i);

   generate
      if (MIX_REG > 1) begin : g_bad
         $error("MIX_REG must be 0 or 1");
      end
      if (MIX_REG == 1) begin : g_reg
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) mix_o <= 1'b0;
            else         mix_o <= raw;
         end
      end else begin : g_comb
         assign mix_o = raw;
      end
   endgenerate
endmodule

// File: rtl/tmr_wave_ctrl.sv
module tmr_wave_ctrl
   import tmr_wave_pkg::*;
#(
   parameter int unsigned MIX_REG = 0
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       run_nar_i,
   input  logic       run_wid_i,
   input  logic       tc_nar_i,
   input  logic       tc_wid_i,
   input  logic       lvl_nar_i,
   input  logic       lvl_wid_i,
   input  logic [1:0] submode_i,
   input  logic [1:0] merge_i,
   output logic       narrow_o,
   output logic       wide_o,
   output logic       mix_o
);
   submode_e mode;
   merge_e   msel;
   logic     go_nar, go_wid, wid_q;

   assign mode = submode_e'(submode_i);
   assign msel = merge_e'(merge_i);

   tmr_wave_seq u_seq (
      .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode),
      .en_nar_i(run_nar_i), .en_wid_i(run_wid_i),
      .tc_nar_i(tc_nar_i), .tc_wid_i(tc_wid_i),
      .run_nar_o(go_nar), .run_wid_o(go_wid)
   );

   tmr_wave_chan u_nar (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(go_nar),
      .tc_i(tc_nar_i), .lvl_i(lvl_nar_i), .out_o(narrow_o)
   );

   tmr_wave_chan u_wid (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(go_wid),
      .tc_i(tc_wid_i), .lvl_i(lvl_wid_i), .out_o(wid_q)
   );

   assign wide_o = submode_i[1] ? submode_i[0] : wid_q;

   tmr_wave_mix #(.MIX_REG(MIX_REG)) u_mix (
      .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(msel),
      .a_i(narrow_o), .b_i(wide_o), .mix_o(mix_o)
   );
endmodule

// File: tb/tmr_wave_ctrl_bench.sv
`timescale 1ns/1ps
module tmr_wave_ctrl_bench;
   logic clk = 1'b0;
   logic rst_ni = 1'b0;
   logic run_nar = 0, run_wid = 0, tc_nar = 0, tc_wid = 0;
   logic lvl_nar = 1, lvl_wid = 1;
   logic [1:0] submode = 2'b00, merge = 2'b00;
   logic narrow, wide, mix;
   int compared = 0, mismatched = 0;
   bit done = 0;

   always #2 clk = ~clk;

   tmr_wave_ctrl u_tmr_wave_ctrl (
      .clk_i(clk), .rst_ni(rst_ni), .run_nar_i(run_nar), .run_wid_i(run_wid),
      .tc_nar_i(tc_nar), .tc_wid_i(tc_wid), .lvl_nar_i(lvl_nar), .lvl_wid_i(lvl_wid),
      .submode_i(submode), .merge_i(merge),
      .narrow_o(narrow), .wide_o(wide), .mix_o(mix)
   );

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic check(input logic act, input logic exp, input string req);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic t_reset();
      tick(); tick();
      check(narrow, 1'b0, "R10 narrow in reset");
      check(wide, 1'b0, "R10 wide in reset");
      rst_ni = 1'b1;
      tick();
      check(narrow, 1'b0, "R5 narrow idle after reset");
   endtask

   task automatic t_single();
      lvl_nar = 0; tick();
      check(narrow, 1'b1, "R5 idle level inverse");
      run_nar = 1; tick();
      check(narrow, 1'b0, "R4 start level");
      tc_nar = 1; tick(); tc_nar = 0;
      check(narrow, 1'b1, "R6 toggle on tc");
      tick();
      check(narrow, 1'b1, "R6 hold without tc");
      check(wide, 1'b0, "R2 wide idle while narrow runs");
      run_nar = 0; tick();
      lvl_nar = 1; tick();
      check(narrow, 1'b0, "R5 idle follows new level");
   endtask

   task automatic t_merge();
      lvl_nar = 0; lvl_wid = 1; tick();
      for (int k = 0; k < 4; k++) begin
         merge = 2'(k); #1;
         check(mix, (k == 1 || k == 3), "R1 merge 1/0");
      end
      lvl_wid = 0; tick();
      for (int k = 0; k < 4; k++) begin
         merge = 2'(k); #1;
         check(mix, (k <= 1), "R1 merge 1/1");
      end
      merge = 2'b00;
   endtask

   task automatic t_force();
      submode = 2'b10; #1;
      check(wide, 1'b0, "R3 forced low same cycle");
      submode = 2'b11; #1;
      check(wide, 1'b1, "R3 forced high same cycle");
      lvl_wid = 1; tick(); lvl_wid = 0; tick();
      check(wide, 1'b1, "R9 level bit ignored when forced");
      submode = 2'b10; tick();
      check(wide, 1'b0, "R9 forced low holds");
      submode = 2'b00; tick();
   endtask

   task automatic t_alt();
      lvl_nar = 1; lvl_wid = 1; tick();
      run_nar = 1; run_wid = 1; submode = 2'b01; tick();
      check(narrow, 1'b1, "R7 narrow starts first");
      check(wide, 1'b0, "R7 wide waits");
      tc_nar = 1; tick(); tc_nar = 0;
      check(narrow, 1'b0, "R7 narrow toggles on tc");
      tick();
      check(narrow, 1'b0, "R7 narrow stopped");
      check(wide, 1'b1, "R7 wide started");
      tc_wid = 1; tick(); tc_wid = 0;
      check(wide, 1'b0, "R7 wide toggles on tc");
      tick();
      check(narrow, 1'b1, "R7 narrow restarted");
      check(wide, 1'b0, "R7 wide stopped");
   endtask

   task automatic t_exit_same_cycle();
      tc_nar = 1; submode = 2'b00; tick(); tc_nar = 0;
      check(wide, 1'b1, "R8 wide started by enable, no handover");
      check(narrow, 1'b0, "R8 narrow toggled");
      tick();
      check(wide, 1'b1, "R8 wide keeps running");
      tc_nar = 1; tick(); tc_nar = 0;
      check(narrow, 1'b1, "R8 narrow still running");
      tc_wid = 1; tick(); tc_wid = 0;
      check(wide, 1'b0, "R2 wide toggles independently");
   endtask

   initial begin
      t_reset();
      t_single();
      t_merge();
      t_force();
      t_alt();
      t_exit_same_cycle();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         compared++; mismatched++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule